// File: doc/BRIEF.md
# I2C Target with Address Wake Request

This block is a bus target (slave) for a two-wire I2C bus. It never creates a START or toggles the clock line itself; it only answers a host-side controller on the bus. The clock and data lines are brought in as plain inputs and driven through active-high "pull low" enables, so the pad ring builds the open-drain drivers. Both lines are resynchronised and glitch filtered by the system clock, which runs many times faster than the bus.

A received address byte is compared against a programmable 7-bit identity and against the broadcast address 0x00. On either hit the block acknowledges and pulses a wake request for the surrounding power controller. Received bytes leave through a valid/ready stream toward the local host. Bytes to be sent arrive through a second valid/ready stream. When the local host is not keeping up, the block stretches the bus clock: it holds SCL low at a byte boundary until there is room for the next received byte or until the next transmit byte has been supplied.

Stream rules: `rx_valid` rises with a new byte on `rx_data` and both stay unchanged until a cycle with `rx_ready` high. While a byte is still pending, the next completed byte is not acknowledged; the bus is held instead. `tx_ready` is high only while the block is waiting for a transmit byte, with the clock stretched; the byte is taken on a cycle where `tx_valid` and `tx_ready` are both high.

Top module: `i2c_wake_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `tx_ready` and `wake_req` are all 0.
- R2: An address byte whose upper seven bits (sent first, MSB first) equal `own_addr` is acknowledged with SDA low during the ninth clock, for either value of the eighth (direction) bit.
- R3: After an address byte that is not acknowledged, the block drives neither line and delivers no data until the next START.
- R4: Each acknowledged address byte produces exactly one single-cycle pulse on `wake_req`, and a rejected one produces none.
- R5: In a write transfer each data byte is received MSB first, acknowledged, and presented on `rx_data` with `rx_valid`.
- R6: While a received byte is pending and not taken, the next completed byte holds SCL low and is not acknowledged until the pending byte is taken; it is then delivered unchanged.
- R7: In a read transfer (direction bit 1) each byte taken on the transmit stream is driven on SDA MSB first, one bit per bus clock.
- R8: Before each transmitted byte, SCL is held low and `tx_ready` stays high until `tx_valid` is supplied.
- R9: A NACK (SDA high) from the controller in the ninth clock of a read byte ends the transfer: SDA is released and `tx_ready` stays low until the next START.
- R10: A START (SDA falling while SCL high) at any point restarts address reception, and a STOP (SDA rising while SCL high) returns the block to idle.
- R11: On an acknowledged address, `gen_call` records whether the broadcast address 0x00 was used, and `xfer_read` records the direction bit.
- R12: The broadcast address 0x00 is acknowledged only with direction bit 0; 0x00 with a read bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Programmed target identity |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | 1 pulls the clock line low (stretching) |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Host takes the received byte |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Block waits for a transmit byte |
| wake_req | output | 1 | One-cycle pulse on an address hit |
| gen_call | output | 1 | Last hit used the broadcast address |
| xfer_read | output | 1 | Last hit was a read transfer |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a two-stage synchroniser and a three-sample glitch filter, driven by a bus model with a 12-cycle half period that honours clock stretching. That short bus period keeps each transaction to a few hundred cycles, which brings a sweep over all 256 address bytes (every identity and both directions) within reach, each one checked against an acknowledge and wake count computed arithmetically. Held-back host streams then open the stretching windows on both the receive and transmit side, and a mid-byte repeated START exercises the restart path.

// File: rtl/i2c_wk_pkg.sv
package i2c_wk_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_STORE, ST_RACK,
    ST_LOAD, ST_TXS, ST_TX, ST_TACK, ST_SKIP
  } wk_state_e;
  localparam logic [6:0] BCAST_ADDR = 7'h00;
endpackage

// File: rtl/i2c_wk_filter.sv
module i2c_wk_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [SYNC_STAGES-1:0] sy;
  logic [CW-1:0]          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy  <= '1;
      run <= '0;
      q_o <= 1'b1;
    end else begin
      sy <= {sy[SYNC_STAGES-2:0], d_i};
      if (sy[SYNC_STAGES-1] == q_o) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        q_o <= sy[SYNC_STAGES-1];
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_wk_cond.sv
module i2c_wk_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f && !scl_p;
  assign scl_fall = !scl_f && scl_p;
  assign start_c  = scl_f && scl_p && sda_p && !sda_f;
  assign stop_c   = scl_f && scl_p && !sda_p && sda_f;
endmodule

// File: rtl/i2c_wk_engine.sv
module i2c_wk_engine
  import i2c_wk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_f,
  input  logic [DATA_W-2:0] own_addr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              wake_req,
  output logic              gen_call,
  output logic              xfer_read
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  wk_state_e         st;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              m_ack;
  logic              is_bcast, hit;

  assign is_bcast = (sh[DATA_W-1:1] == BCAST_ADDR[DATA_W-2:0]) && !sh[0];
  assign hit      = (sh[DATA_W-1:1] == own_addr) || is_bcast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      m_ack     <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      wake_req  <= 1'b0;
      gen_call  <= 1'b0;
      xfer_read <= 1'b0;
    end else begin
      wake_req <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (start_c) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else if (stop_c) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(DATA_W)) begin
              if (st == ST_RX) begin
                st <= ST_STORE;
              end else if (hit) begin
                st        <= ST_AACK;
                wake_req  <= 1'b1;
                gen_call  <= is_bcast;
                xfer_read <= sh[0];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            st  <= xfer_read ? ST_LOAD : ST_RX;
          end
          ST_STORE: if (!rx_valid) begin
            rx_data  <= sh;
            rx_valid <= 1'b1;
            st       <= ST_RACK;
          end
          ST_RACK: if (scl_fall) begin
            cnt <= '0;
            st  <= ST_RX;
          end
          ST_LOAD: if (tx_valid) begin
            sh  <= tx_data;
            cnt <= '0;
            st  <= ST_TXS;
          end
          ST_TXS: st <= ST_TX;
          ST_TX: if (scl_fall) begin
            if (cnt == CNT_W'(DATA_W - 1)) begin
              st <= ST_TACK;
            end else begin
              sh  <= {sh[DATA_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
          ST_TACK: begin
            if (scl_rise) m_ack <= !sda_f;
            else if (scl_fall) st <= m_ack ? ST_LOAD : ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_ready = (st == ST_LOAD);
  assign scl_oe   = (st == ST_STORE) || (st == ST_LOAD) || (st == ST_TXS);
  assign sda_oe   = (st == ST_AACK) || (st == ST_RACK)
                 || ((st == ST_STORE) && !rx_valid)
                 || (((st == ST_TXS) || (st == ST_TX)) && !sh[DATA_W-1]);
endmodule

// File: rtl/i2c_wake_target.sv
module i2c_wake_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              wake_req,
  output logic              gen_call,
  output logic              xfer_read
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw, filt;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_wk_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .d_i(raw[g]), .q_o(filt[g])
    );
  end

  i2c_wk_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(filt[1]), .sda_f(filt[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2c_wk_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_f(filt[0]), .own_addr(own_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .wake_req(wake_req), .gen_call(gen_call),
    .xfer_read(xfer_read)
  );
endmodule

// File: rtl/i2c_wk_checker.sv
module i2c_wk_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              wake_req
);
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  p_wake_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sda_oe);

  p_tx_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (tx_ready && scl_oe));

  p_sda_edge_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);
endmodule

bind i2c_wake_target i2c_wk_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .wake_req(wake_req)
);

// File: tb/i2c_wake_target_bench.sv
`timescale 1ns/1ps
module i2c_wake_target_bench;
  localparam int HP = 12;
  localparam int GAP = 4;
  localparam logic [6:0] OWN = 7'h3C;

  logic clk = 0, rst_n = 0;
  logic m_scl_low = 0, m_sda_low = 0;
  logic scl_oe, sda_oe, rx_valid, tx_ready, wake_req, gen_call, xfer_read;
  logic [7:0] rx_data, tx_data;
  logic rx_auto = 1, tx_auto = 1;
  logic scl_line, sda_line;
  logic [7:0] tx_q [16];
  logic [7:0] rx_log [16];
  int tx_k = 0, rx_n = 0, wake_n = 0, drv_n = 0;
  bit tx_pend = 0;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);
  assign tx_data  = tx_q[tx_k % 16];

  i2c_wake_target u_i2c_wake_target (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_auto), .tx_data(tx_data), .tx_valid(tx_auto), .tx_ready(tx_ready),
    .wake_req(wake_req), .gen_call(gen_call), .xfer_read(xfer_read)
  );

  always @(negedge clk) begin
    if (tx_pend) begin tx_k++; tx_pend = 0; end
    if (tx_auto && tx_ready) tx_pend = 1;
    if (rx_valid && rx_auto) begin rx_log[rx_n % 16] = rx_data; rx_n++; end
    if (wake_req) wake_n++;
    if (sda_oe) drv_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda_low = 0; hp(GAP);
    m_scl_low = 0; wait_scl; hp(HP);
    m_sda_low = 1; hp(HP);
    m_scl_low = 1; hp(GAP);
  endtask

  task automatic bus_stop;
    m_sda_low = 1; hp(HP);
    m_scl_low = 0; wait_scl; hp(HP);
    m_sda_low = 0; hp(HP);
  endtask

  task automatic bit_io(input bit b, output bit r);
    m_sda_low = !b; hp(HP);
    m_scl_low = 0; wait_scl; hp(HP/2);
    r = sda_line; hp(HP/2);
    m_scl_low = 1; hp(GAP);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    bit r;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); v = {v[6:0], r}; end
    bit_io(!mack, r);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    bit ack, exp_ack;
    int w0, r0, d0, k0;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) tx_q[i] = 8'((i * 37 + 11) & 8'hFF);
    hp(5);
    chk({scl_oe, sda_oe, rx_valid, tx_ready, wake_req} == 5'b0, "R1 reset",
        {scl_oe, sda_oe, rx_valid, tx_ready, wake_req}, 0);
    rst_n = 1; hp(5);
    chk({scl_oe, sda_oe, rx_valid, tx_ready, wake_req} == 5'b0, "R1 idle",
        {scl_oe, sda_oe, rx_valid, tx_ready, wake_req}, 0);

    // R2 R4 R11 R12: every address byte, both directions
    for (int a = 0; a < 256; a++) begin
      w0 = wake_n; k0 = tx_k;
      exp_ack = (a[7:1] == OWN) || (a == 0);
      bus_start;
      write_byte(8'(a), ack);
      chk(ack == exp_ack, (a == 1) ? "R12 bcast read" : "R2 ack", ack, exp_ack);
      chk(wake_n - w0 == int'(exp_ack), "R4 wake count", wake_n - w0, exp_ack);
      if (exp_ack) begin
        chk(gen_call == (a[7:1] == 0), "R11 gen_call", gen_call, a[7:1] == 0);
        chk(xfer_read == a[0], "R11 xfer_read", xfer_read, a[0]);
        if (a[0]) begin
          read_byte(1'b0, v);
          chk(v == tx_q[k0 % 16], "R7 sweep read", v, tx_q[k0 % 16]);
        end
      end
      bus_stop;
    end

    // R3: rejected address, then data is ignored
    r0 = rx_n; d0 = drv_n;
    bus_start;
    write_byte({OWN ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R3 no ack", ack, 0);
    write_byte(8'h00, ack);
    chk(!ack, "R3 data ignored", ack, 0);
    chk(drv_n == d0 && rx_n == r0, "R3 quiet", drv_n - d0 + rx_n - r0, 0);
    bus_stop;

    // R5: write burst
    r0 = rx_n;
    bus_start;
    write_byte({OWN, 1'b0}, ack);
    write_byte(8'hA5, ack); chk(ack, "R5 ack b0", ack, 1);
    write_byte(8'h3C, ack); chk(ack, "R5 ack b1", ack, 1);
    write_byte(8'hFE, ack); chk(ack, "R5 ack b2", ack, 1);
    bus_stop;
    chk(rx_n - r0 == 3, "R5 count", rx_n - r0, 3);
    chk(rx_log[r0 % 16] == 8'hA5, "R5 byte0", rx_log[r0 % 16], 8'hA5);
    chk(rx_log[(r0 + 1) % 16] == 8'h3C, "R5 byte1", rx_log[(r0 + 1) % 16], 8'h3C);
    chk(rx_log[(r0 + 2) % 16] == 8'hFE, "R5 byte2", rx_log[(r0 + 2) % 16], 8'hFE);

    // R6: receive stretching
    r0 = rx_n;
    bus_start;
    write_byte({OWN, 1'b0}, ack);
    rx_auto = 0;
    write_byte(8'h5B, ack);
    fork
      write_byte(8'hC4, ack);
      begin
        hp(9 * (HP + GAP) + 150);
        chk(!scl_line, "R6 scl held", scl_line, 0);
        chk(rx_valid && rx_data == 8'h5B, "R6 pending kept", rx_data, 8'h5B);
        rx_auto = 1;
      end
    join
    chk(ack, "R6 late ack", ack, 1);
    bus_stop;
    chk(rx_n - r0 == 2 && rx_log[(r0 + 1) % 16] == 8'hC4, "R6 second byte",
        rx_log[(r0 + 1) % 16], 8'hC4);

    // R7 R8 R9: read with stretching and final NACK
    tx_auto = 0; k0 = tx_k;
    bus_start;
    write_byte({OWN, 1'b1}, ack);
    chk(ack, "R7 read addr ack", ack, 1);
    fork
      read_byte(1'b1, v);
      begin
        hp(150);
        chk(!scl_line && tx_ready, "R8 stretch for tx", {scl_line, tx_ready}, 1);
        tx_auto = 1;
      end
    join
    chk(v == tx_q[k0 % 16], "R7 byte0", v, tx_q[k0 % 16]);
    read_byte(1'b0, v);
    chk(v == tx_q[(k0 + 1) % 16], "R7 byte1", v, tx_q[(k0 + 1) % 16]);
    d0 = drv_n;
    hp(60);
    chk(!tx_ready && drv_n == d0 && tx_k == k0 + 2, "R9 nack ends", tx_k - k0, 2);
    bus_stop;

    // R10: repeated START in the middle of a data byte
    r0 = rx_n;
    begin
      bit r;
      bus_start;
      write_byte({OWN, 1'b0}, ack);
      bit_io(1'b0, r); bit_io(1'b1, r); bit_io(1'b0, r);
      bus_start;
      write_byte({OWN, 1'b0}, ack);
      chk(ack, "R10 restart addr ack", ack, 1);
      write_byte(8'h81, ack);
      bus_stop;
    end
    chk(rx_n - r0 == 1 && rx_log[r0 % 16] == 8'h81, "R10 restart data",
        rx_log[r0 % 16], 8'h81);
    chk(!scl_oe && !sda_oe, "R10 idle after stop", {scl_oe, sda_oe}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule